// File: doc/BRIEF.md
# Paddle potentiometer line counter

This block measures how long each of four analog paddle capacitors takes to charge, with one scanline as the unit. Software starts a measurement by writing the control register with its start bit set. That write clears all four counters and arms the scan. From then on, every horizontal-sync strobe adds one to each counter whose pin is not driven high as an output.

The four 8-bit counts are read back as two 16-bit words, one word for each of the two ports. A status flag shows whether a scan is still running. A counter wraps from 255 back to 0 rather than stopping, so an unconnected pin keeps cycling for as long as the scan lasts. The scan ends by itself only when every pin is driven high, because then no counter can ever change again.

Top module: `paddle_line_counter`

## Requirements
- R1: After reset, both read words are 0x0000 and `scan_active` is 0.
- R2: A write with `ctl_wdata[0]` = 1 clears all four counters to zero and sets `scan_active` on the next cycle.
- R3: Each `hsync_tick` cycle while `scan_active` is 1 adds one to every counter that is not frozen. The read words are combinational from the counters, so the new value is visible in the cycle after the strobe.
- R4: A counter at 255 goes to 0 on its next step, and the scan keeps running.
- R5: Counter k (0 = port 0 X, 1 = port 0 Y, 2 = port 1 X, 3 = port 1 Y) is frozen when both control bits 8+2k (data) and 9+2k (output enable) are set, meaning the pin is driven high. A frozen counter does not advance. Example: 0x0F01 freezes both port 0 counters while both port 1 counters still count.
- R6: Read word p carries counter 2p+1 (the Y pin) in bits 15:8 and counter 2p (the X pin) in bits 7:0. With all pins free, five strobes after a start read 0x0505.
- R7: A strobe during a scan on which every counter is frozen clears `scan_active`. After a 0xFFFF write and 32 strobes, both words read zero and the scan is stopped.
- R8: `hsync_tick` while `scan_active` is 0 is ignored, and the counters keep their values.
- R9: A start write and a strobe in the same cycle give priority to the start, so all counters read zero afterwards.
- R10: A write with bit 0 clear updates only the pin configuration (bits 15:8). It leaves the counters and `scan_active` unchanged, and the new freeze mask applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control write data: bit 0 is start, bits 15:8 are the pin drive configuration |
| hsync_tick | input | 1 | One-cycle pulse per horizontal sync |
| port0_word | output | 16 | Port 0 counts: Y in the high byte, X in the low byte |
| port1_word | output | 16 | Port 1 counts: Y in the high byte, X in the low byte |
| scan_active | output | 1 | A scan is running |

## Verification
Two functions can fall in the same cycle: a start write and a line strobe. The bench provokes this by driving `ctl_wr` with bit 0 set and `hsync_tick` on the same clock, both while counters hold non-zero values and while a freeze mask is changing. It passes only if every word reads zero in the following cycle and the next strobe produces exactly one count. Where a configuration-only write meets a strobe, the bench checks that the strobe still uses the old freeze mask.

// File: rtl/pot_pkg.sv
// Package: shared sizing for the paddle line counter.
// Assumes two ports with an X and a Y pin each, and one 16-bit word per port.
package pot_pkg;
    localparam int POT_CNT_W       = 8;
    localparam int POT_PORTS       = 2;
    localparam int POT_PINS_PER    = 2;
    localparam int POT_PINS        = POT_PORTS * POT_PINS_PER;
    localparam int POT_CTL_W       = 16;
    localparam int POT_CFG_LSB     = 8;
    localparam int POT_START_BIT   = 0;
endpackage

// File: rtl/pot_cfg_reg.sv
// Module: pot_cfg_reg
// Holds the pin drive configuration taken from control writes, and gives a
// per-pin "driven high" mask plus a start pulse.
// Assumes each pin owns two adjacent bits from CFG_LSB upward: data bit low,
// output-enable bit high. The mask reflects the registered value, so a new
// configuration takes effect on the cycle after the write.
module pot_cfg_reg #(
    parameter int NPINS     = 4,
    parameter int CTL_W     = 16,
    parameter int CFG_LSB   = 8,
    parameter int START_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output logic             start,
    output logic [NPINS-1:0] drive_hi
);
    localparam int CFG_W = 2 * NPINS;

    logic [CFG_W-1:0] cfg_q;

    // A start is any write carrying the start bit.
    assign start = wr & wdata[START_BIT];

    // Capture the pin configuration bits on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)  cfg_q <= '0;
        else if (wr) cfg_q <= wdata[CFG_LSB +: CFG_W];
    end

    // A pin is driven high when its data and output-enable bits are both set.
    for (genvar k = 0; k < NPINS; k++) begin : g_mask
        assign drive_hi[k] = cfg_q[2*k] & cfg_q[2*k+1];
    end
endmodule

// File: rtl/pot_scan_ctrl.sv
// Module: pot_scan_ctrl
// Keeps the scan-running flag and turns line strobes into counter steps.
// Assumes start outranks a strobe in the same cycle, and that a strobe on which
// no pin can count ends the scan.
module pot_scan_ctrl #(
    parameter int NPINS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hsync,
    input  logic [NPINS-1:0] drive_hi,
    output logic             running,
    output logic             step
);
    logic none_free;

    // A step happens only on a strobe in a running scan with no start pending.
    assign step      = hsync & running & ~start;
    assign none_free = &drive_hi;

    // Running is set by start and cleared when a step finds every pin frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                 running <= 1'b0;
        else if (start)             running <= 1'b1;
        else if (step && none_free) running <= 1'b0;
    end

    // R2
    start_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> running);
    // R7
    all_frozen_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && running && !start && (&drive_hi)) |=> !running);
    // R8
    idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !start) |=> !running);
endmodule

// File: rtl/pot_line_ctr.sv
// Module: pot_line_ctr
// One wrapping charge-time counter for one pin.
// Assumes clear outranks step, and that a frozen pin ignores steps.
module pot_line_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             frozen,
    output logic [CNT_W-1:0] count
);
    // Clear on start, else add one per step unless frozen; wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)               count <= '0;
        else if (clear)           count <= '0;
        else if (step && !frozen) count <= count + CNT_W'(1);
    end

    // R2
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0));
    // R3
    step_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !frozen && !clear) |=> (count == $past(count) + CNT_W'(1)));
    // R5
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clear) |=> $stable(count));
endmodule

// File: rtl/paddle_line_counter.sv
// Module: paddle_line_counter (top)
// Four scanline-unit charge counters for the paddle pins, read as one 16-bit
// word per port. Assumes hsync_tick is a single-cycle pulse per line.
module paddle_line_counter #(
    parameter int CNT_W     = pot_pkg::POT_CNT_W,
    parameter int PORTS     = pot_pkg::POT_PORTS,
    parameter int CTL_W     = pot_pkg::POT_CTL_W,
    parameter int CFG_LSB   = pot_pkg::POT_CFG_LSB,
    parameter int START_BIT = pot_pkg::POT_START_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic [CTL_W-1:0]   ctl_wdata,
    input  logic               hsync_tick,
    output logic [2*CNT_W-1:0] port0_word,
    output logic [2*CNT_W-1:0] port1_word,
    output logic               scan_active
);
    localparam int NPINS  = PORTS * pot_pkg::POT_PINS_PER;
    localparam int WORD_W = 2 * CNT_W;

    logic                 start;
    logic                 step;
    logic [NPINS-1:0]     drive_hi;
    logic [CNT_W-1:0]     cnt [NPINS];
    logic [WORD_W-1:0]    words [PORTS];

    pot_cfg_reg #(.NPINS(NPINS), .CTL_W(CTL_W), .CFG_LSB(CFG_LSB),
                  .START_BIT(START_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .start(start), .drive_hi(drive_hi));

    pot_scan_ctrl #(.NPINS(NPINS)) u_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .hsync(hsync_tick),
        .drive_hi(drive_hi), .running(scan_active), .step(step));

    // One counter per pin, each gated by its own freeze bit.
    for (genvar k = 0; k < NPINS; k++) begin : g_ctr
        pot_line_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .clear(start), .step(step),
            .frozen(drive_hi[k]), .count(cnt[k]));
    end

    // Pack each port word: Y pin high byte, X pin low byte.
    for (genvar p = 0; p < PORTS; p++) begin : g_word
        assign words[p] = {cnt[2*p+1], cnt[2*p]};
    end

    assign port0_word = words[0];
    assign port1_word = words[1];

    // Bits between start and the configuration field carry no meaning.
    logic unused_ctl;
    assign unused_ctl = ^ctl_wdata;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scan_active && !(ctl_wr && ctl_wdata[START_BIT]))
            |=> ($stable(port0_word) && $stable(port1_word)));
    // R9
    start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata[START_BIT] && hsync_tick)
            |=> (port0_word == '0 && port1_word == '0));
endmodule

// File: tb/sim_paddle_line_counter.sv
module sim_paddle_line_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        hsync_tick = 1'b0;
    logic [15:0] port0_word, port1_word;
    logic        scan_active;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    paddle_line_counter u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .hsync_tick(hsync_tick), .port0_word(port0_word),
        .port1_word(port1_word), .scan_active(scan_active));

    // Row fields: wr, wdata[15:0], hsync, exp p0[15:0], exp p1[15:0], exp run
    localparam int NV = 16;
    localparam logic [50:0] VEC [NV] = '{
        {1'b1, 16'h0001, 1'b0, 16'h0000, 16'h0000, 1'b1}, // R2 start
        {1'b0, 16'h0000, 1'b1, 16'h0101, 16'h0101, 1'b1}, // R3
        {1'b0, 16'h0000, 1'b1, 16'h0202, 16'h0202, 1'b1}, // R3
        {1'b0, 16'h0000, 1'b1, 16'h0303, 16'h0303, 1'b1}, // R3
        {1'b0, 16'h0000, 1'b1, 16'h0404, 16'h0404, 1'b1}, // R3
        {1'b0, 16'h0000, 1'b1, 16'h0505, 16'h0505, 1'b1}, // R6 five strobes
        {1'b0, 16'h0000, 1'b0, 16'h0505, 16'h0505, 1'b1}, // R3 no strobe
        {1'b1, 16'h0F01, 1'b1, 16'h0000, 16'h0000, 1'b1}, // R9 start+strobe
        {1'b0, 16'h0000, 1'b1, 16'h0000, 16'h0101, 1'b1}, // R5 port0 frozen
        {1'b0, 16'h0000, 1'b1, 16'h0000, 16'h0202, 1'b1}, // R5
        {1'b1, 16'h3000, 1'b0, 16'h0000, 16'h0202, 1'b1}, // R10 cfg only
        {1'b0, 16'h0000, 1'b1, 16'h0101, 16'h0302, 1'b1}, // R5 port1 X frozen
        {1'b1, 16'hFF00, 1'b0, 16'h0101, 16'h0302, 1'b1}, // R10
        {1'b0, 16'h0000, 1'b1, 16'h0101, 16'h0302, 1'b0}, // R7 all frozen
        {1'b0, 16'h0000, 1'b1, 16'h0101, 16'h0302, 1'b0}, // R8 ignored
        {1'b1, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 1'b1}  // R2
    };

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample just after the edge.
    task automatic cycle(input logic wr, input logic [15:0] d, input logic hs);
        @(negedge clk);
        ctl_wr = wr; ctl_wdata = d; hsync_tick = hs;
        @(posedge clk);
        #1;
        ctl_wr = 1'b0; ctl_wdata = '0; hsync_tick = 1'b0;
    endtask

    task automatic check_all(input string req, input logic [15:0] e0,
                             input logic [15:0] e1, input logic er);
        check({req, " port0"}, port0_word, e0);
        check({req, " port1"}, port1_word, e1);
        check({req, " run"}, {15'd0, scan_active}, {15'd0, er});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset", 16'h0000, 16'h0000, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i][50], VEC[i][49:34], VEC[i][33]);
            check_all($sformatf("vec%0d", i), VEC[i][32:17], VEC[i][16:1],
                      VEC[i][0]);
        end

        // R7: after 0xFFFF start, 32 strobes leave zeros and a stopped scan
        for (int i = 0; i < 32; i++) cycle(1'b0, 16'h0000, 1'b1);
        check_all("R7 32 strobes", 16'h0000, 16'h0000, 1'b0);

        // R4: wrap from 255 to 0 with the scan still running
        cycle(1'b1, 16'h0001, 1'b0);
        for (int i = 0; i < 255; i++) cycle(1'b0, 16'h0000, 1'b1);
        check_all("R4 at 255", 16'hFFFF, 16'hFFFF, 1'b1);
        cycle(1'b0, 16'h0000, 1'b1);
        check_all("R4 wrapped", 16'h0000, 16'h0000, 1'b1);

        // R9: start with strobe on non-zero counts, then exactly one count
        cycle(1'b0, 16'h0000, 1'b1);
        cycle(1'b1, 16'h0001, 1'b1);
        check_all("R9 start wins", 16'h0000, 16'h0000, 1'b1);
        cycle(1'b0, 16'h0000, 1'b1);
        check_all("R9 next step", 16'h0101, 16'h0101, 1'b1);

        // R10: config write together with a strobe uses the old mask
        cycle(1'b1, 16'hFF00, 1'b1);
        check_all("R10 old mask", 16'h0202, 16'h0202, 1'b1);

        // R1: reset mid-scan returns to the idle state
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check_all("R1 mid reset", 16'h0000, 16'h0000, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500us;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule